// File: doc/BRIEF.md
# Revolution Marker with Direction-Qualified Count Strobe

This block sits next to an up/down position counter. It watches each step of that counter. When a step carries the counter across its major carry, it raises a revolution marker. The carry is crossed either upward, from all ones to zero, or downward, from zero to all ones. Alongside the marker it produces a registered motion-direction output. It also produces a single-cycle count strobe tagged with that direction, which lets an external revolution counter step up or down without false counts.

The marker stays high for a programmable minimum time, given in nanoseconds and converted to clock cycles. In quiet operation it drops once that time has elapsed. If the direction flips while the marker is high, the marker is held until the direction has stayed unchanged across two step strobes. Only then is it released. A further wrap arriving while the marker is high restarts the marker window.

Top module: `rev_marker`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are 0 after that edge.
- R2: `dir_o` equals the `dir_in` value sampled at the previous clock edge (1 = upward, 0 = downward).
- R3: A step is taken only on a rising strobe: `busy_in` is 1 at this edge and was 0 at the previous edge. Holding `busy_in` high produces no further steps.
- R4: An upward wrap is a step with `dir_in` = 1 and `pos_in` all ones. After it, `marker_o` = 1, `rev_stb_o` = 1 for exactly one cycle and `rev_up_o` = 1.
- R5: A downward wrap is a step with `dir_in` = 0 and `pos_in` = 0. After it, `marker_o` = 1, `rev_stb_o` = 1 for one cycle and `rev_up_o` = 0.
- R6: Steps at any other `pos_in` value, and cycles without a step, never raise `rev_stb_o` and never raise `marker_o`.
- R7: `marker_o` stays high for at least MIN_HIGH = ceil(MIN_NS/CLK_NS) cycles. If `dir_in` does not change while it is high, it is high for exactly MIN_HIGH cycles.
- R8: Suppose `dir_in` differs from `dir_o` in a cycle while the marker is high. The marker then stays high until two steps have been taken with no such difference since. A step in the same cycle as a difference does not count. The marker falls one cycle after the second qualifying step, or when the minimum window ends if that is later.
- R9: A wrap step while the marker is high emits a new strobe with the new direction. It restarts the MIN_HIGH window and discards any pending direction condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_in | input | 1 | Step direction, 1 = up |
| busy_in | input | 1 | Step strobe; its rising edge marks one counter step |
| pos_in | input | POS_W | Counter value before the step in progress |
| dir_o | output | 1 | Registered motion direction |
| marker_o | output | 1 | Revolution marker |
| rev_stb_o | output | 1 | One-cycle count strobe for a revolution counter |
| rev_up_o | output | 1 | Direction for the revolution counter, valid with the strobe |

## Verification
The bench builds the block with POS_W = 4, CLK_NS = 5 and MIN_NS = 40, which gives an 8-cycle minimum marker window. The narrow counter lets both wrap values be driven directly. The short window lets a single run cover several full marker lifetimes, a restart inside a window, and a direction reversal that holds the marker well past its minimum time. Long strobe levels and repeated direction toggles between steps are also reached within a few hundred cycles.

// File: rtl/rev_marker_pkg.sv
// Shared helpers for the revolution marker.
// Assumes times are given in whole nanoseconds.
package rev_marker_pkg;

    // Converts a duration to a cycle count, rounding up, never below 1.
    function automatic int cycles_for(input int dur_ns, input int clk_ns);
        int c;
        c = (dur_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    typedef logic [1:0] settle_cnt_t;

endpackage

// File: rtl/rev_step_sense.sv
// Step and direction sensing.
// Registers the strobe and the direction. It flags the rising edge of the
// strobe and any cycle where the incoming direction differs from the registered one.
// Assumes inputs are synchronous to clk.
module rev_step_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_in,
    input  logic busy_in,
    output logic dir_q,
    output logic step,
    output logic dir_chg
);
    logic busy_q;

    // Keep last strobe level and last direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            busy_q <= busy_in;
            dir_q  <= dir_in;
        end
    end

    // Edge and change flags.
    always_comb begin
        step    = busy_in & ~busy_q;
        dir_chg = dir_in ^ dir_q;
    end
endmodule

// File: rtl/rev_wrap_detect.sv
// Major-carry detector.
// Reports whether a step in the given direction from the presented counter
// value crosses the carry.
// Assumes pos is the value before the step.
module rev_wrap_detect #(
    parameter int POS_W = 12
) (
    input  logic             dir_up,
    input  logic [POS_W-1:0] pos,
    output logic             wrap
);
    // Upward crosses at all ones, downward at zero.
    always_comb begin
        wrap = dir_up ? (&pos) : ~(|pos);
    end
endmodule

// File: rtl/rev_marker_timer.sv
// Marker state machine.
// Raises the marker on a wrap step and holds it for MIN_HIGH cycles. If the
// direction changes while high, it extends the marker until two steps are
// seen with no change. It also issues the one-cycle count strobe with its direction.
module rev_marker_timer #(
    parameter int MIN_HIGH = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_hit,
    input  logic step,
    input  logic dir_chg,
    input  logic dir_in,
    output logic marker,
    output logic stb,
    output logic stb_up
);
    import rev_marker_pkg::*;

    localparam int HOLD_W = $clog2(MIN_HIGH + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_HIGH - 1);

    logic [HOLD_W-1:0] hold;
    logic              moved;
    settle_cnt_t       settle;
    logic              may_fall;

    // Release allowed once the window is over and the direction has settled.
    always_comb begin
        may_fall = (hold == '0) && !dir_chg && (!moved || settle == 2'd2);
    end

    // Marker, window, settle tracking and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marker <= 1'b0;
            hold   <= '0;
            moved  <= 1'b0;
            settle <= '0;
            stb    <= 1'b0;
            stb_up <= 1'b0;
        end else begin
            stb <= wrap_hit;
            if (wrap_hit) begin
                marker <= 1'b1;
                hold   <= HOLD_LOAD;
                moved  <= 1'b0;
                settle <= '0;
                stb_up <= dir_in;
            end else if (marker) begin
                if (hold != '0) begin
                    hold <= hold - 1'b1;
                end
                if (dir_chg) begin
                    moved  <= 1'b1;
                    settle <= '0;
                end else if (step && settle != 2'd2) begin
                    settle <= settle + 1'b1;
                end
                if (may_fall) begin
                    marker <= 1'b0;
                    moved  <= 1'b0;
                    settle <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/rev_marker.sv
// Revolution marker top level.
// Joins step sensing, carry detection and the marker timer.
// Assumes pos_in holds the counter value before the step whose strobe is rising.
module rev_marker #(
    parameter int POS_W  = 12,
    parameter int CLK_NS = 5,
    parameter int MIN_NS = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_in,
    input  logic             busy_in,
    input  logic [POS_W-1:0] pos_in,
    output logic             dir_o,
    output logic             marker_o,
    output logic             rev_stb_o,
    output logic             rev_up_o
);
    import rev_marker_pkg::*;

    localparam int MIN_HIGH = cycles_for(MIN_NS, CLK_NS);

    logic step;
    logic dir_chg;
    logic wrap;
    logic wrap_hit;

    rev_step_sense u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_in (dir_in),
        .busy_in(busy_in),
        .dir_q  (dir_o),
        .step   (step),
        .dir_chg(dir_chg)
    );

    rev_wrap_detect #(.POS_W(POS_W)) u_wrap (
        .dir_up(dir_in),
        .pos   (pos_in),
        .wrap  (wrap)
    );

    // Only a real step can wrap.
    always_comb begin
        wrap_hit = step & wrap;
    end

    rev_marker_timer #(.MIN_HIGH(MIN_HIGH)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_hit(wrap_hit),
        .step    (step),
        .dir_chg (dir_chg),
        .dir_in  (dir_in),
        .marker  (marker_o),
        .stb     (rev_stb_o),
        .stb_up  (rev_up_o)
    );
endmodule

// File: rtl/rev_marker_chk.sv
// Assertion checker for rev_marker, attached by bind.
// Uses only the top-level ports and its own strobe history.
module rev_marker_chk #(
    parameter int POS_W    = 12,
    parameter int MIN_HIGH = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dir_in,
    input logic             busy_in,
    input logic [POS_W-1:0] pos_in,
    input logic             dir_o,
    input logic             marker_o,
    input logic             rev_stb_o,
    input logic             rev_up_o
);
    logic bp;
    int   run;

    // Strobe history and length of the current marker run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp  <= 1'b0;
            run <= 0;
        end else begin
            bp  <= busy_in;
            run <= marker_o ? run + 1 : 0;
        end
    end

    a_r2_dir_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dir_o == $past(dir_in));

    a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_in && !bp && dir_in && (&pos_in)) |=> (rev_stb_o && marker_o && rev_up_o));

    a_r5_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_in && !bp && !dir_in && !(|pos_in)) |=> (rev_stb_o && marker_o && !rev_up_o));

    a_r6_stb_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        rev_stb_o |-> ($past(busy_in) && !$past(bp)));

    a_r7_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(marker_o) |-> run >= MIN_HIGH);

    a_r8_hold_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (marker_o && (dir_in != dir_o)) |=> marker_o);
endmodule

bind rev_marker rev_marker_chk #(.POS_W(POS_W), .MIN_HIGH(MIN_HIGH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_in   (dir_in),
    .busy_in  (busy_in),
    .pos_in   (pos_in),
    .dir_o    (dir_o),
    .marker_o (marker_o),
    .rev_stb_o(rev_stb_o),
    .rev_up_o (rev_up_o)
);

// File: tb/rev_marker_bench.sv
// Bench for rev_marker: behavioural reference compared every cycle, plus targeted checks.
module rev_marker_bench;
    localparam int POS_W  = 4;
    localparam int CLK_NS = 5;
    localparam int MIN_NS = 40;
    localparam int MINC   = 8;
    localparam int TOP    = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dir_in = 1'b0;
    logic             busy_in = 1'b0;
    logic [POS_W-1:0] pos_in = 4'd5;
    logic             dir_o, marker_o, rev_stb_o, rev_up_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference state.
    int m_mk = 0, m_left = 0, m_moved = 0, m_good = 0;
    int m_stb = 0, m_up = 0, m_dir = 0, m_bq = 0;

    always #2.5 clk = ~clk;

    rev_marker #(.POS_W(POS_W), .CLK_NS(CLK_NS), .MIN_NS(MIN_NS)) u_rev_marker (
        .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .busy_in(busy_in), .pos_in(pos_in),
        .dir_o(dir_o), .marker_o(marker_o), .rev_stb_o(rev_stb_o), .rev_up_o(rev_up_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: behaviour taken from the requirements.
    always @(posedge clk) begin
        automatic int stepped, changed, wrapped, n_mk, n_left, n_moved, n_good;
        if (!rst_n) begin
            m_mk = 0; m_left = 0; m_moved = 0; m_good = 0;
            m_stb = 0; m_up = 0; m_dir = 0; m_bq = 0;
        end else begin
            stepped = (busy_in && m_bq == 0);
            changed = (dir_in != m_dir);
            wrapped = stepped && (dir_in ? (pos_in == TOP) : (pos_in == 0));
            n_mk = m_mk; n_left = m_left; n_moved = m_moved; n_good = m_good;
            if (wrapped) begin
                n_mk = 1; n_left = MINC - 1; n_moved = 0; n_good = 0;
                m_up = dir_in;
            end else if (m_mk) begin
                if (m_left > 0) n_left = m_left - 1;
                if (changed) begin n_moved = 1; n_good = 0; end
                else if (stepped && m_good < 2) n_good = m_good + 1;
                if (m_left == 0 && !changed && (!m_moved || m_good == 2)) begin
                    n_mk = 0; n_moved = 0; n_good = 0;
                end
            end
            m_stb = wrapped;
            m_mk = n_mk; m_left = n_left; m_moved = n_moved; m_good = n_good;
            m_dir = dir_in; m_bq = busy_in;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 dir_o", dir_o, m_dir);
            chk("R7,R8 marker_o", marker_o, m_mk);
            chk("R4 rev_stb_o", rev_stb_o, m_stb);
            chk("R5 rev_up_o", rev_up_o, m_up);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One step: direction set a cycle ahead, then a one-cycle strobe.
    task automatic step(input logic d, input int p);
        @(negedge clk); dir_in = d;
        @(negedge clk); pos_in = POS_W'(p); busy_in = 1'b1;
        @(negedge clk); busy_in = 1'b0; pos_in = 4'd5;
    endtask

    task automatic pulse();
        @(negedge clk); busy_in = 1'b1;
        @(negedge clk); busy_in = 1'b0;
    endtask

    initial begin
        int hi;
        tick(3);
        chk("R1 marker in reset", marker_o, 0);
        chk("R1 strobe in reset", rev_stb_o, 0);
        chk("R1 dir in reset", dir_o, 0);
        rst_n = 1'b1;

        // R6: ordinary steps.
        step(1, 3); step(1, 14); step(0, 1);
        chk("R6 no marker on plain step", marker_o, 0);

        // R4 and R7: upward wrap, exact width.
        step(1, TOP);
        chk("R4 strobe after up wrap", rev_stb_o, 1);
        chk("R4 up flag", rev_up_o, 1);
        hi = 0;
        while (marker_o && hi < 100) begin hi++; tick(1); end
        chk("R7 quiet marker width", hi, MINC);
        chk("R4 strobe single cycle", rev_stb_o, 0);

        // R5: downward wrap.
        tick(2);
        step(0, 0);
        chk("R5 strobe after down wrap", rev_stb_o, 1);
        chk("R5 down flag", rev_up_o, 0);
        tick(12);

        // R3: long strobe level counts once.
        @(negedge clk); dir_in = 1'b1;
        @(negedge clk); pos_in = TOP; busy_in = 1'b1;
        tick(1);
        chk("R3 first rise wraps", rev_stb_o, 1);
        tick(3);
        chk("R3 held level no new strobe", rev_stb_o, 0);
        busy_in = 1'b0; pos_in = 4'd5;
        tick(12);
        chk("R3 marker cleared after one rise", marker_o, 0);

        // R8: reversal while high holds the marker.
        step(1, TOP);
        @(negedge clk); dir_in = 1'b0;
        tick(14);
        chk("R8 held past window after reversal", marker_o, 1);
        pulse();
        tick(2);
        chk("R8 held after one step", marker_o, 1);
        pulse();
        tick(1);
        chk("R8 released after two steps", marker_o, 0);

        // R8: several toggles between steps restart the count.
        tick(3);
        step(0, 0);
        @(negedge clk); dir_in = 1'b1;
        pulse();
        @(negedge clk); dir_in = 1'b0;
        @(negedge clk); dir_in = 1'b1;
        pulse();
        tick(12);
        chk("R8 toggles keep marker high", marker_o, 1);
        pulse(); pulse();
        tick(2);
        chk("R8 released after settling", marker_o, 0);

        // R9: wrap inside a live window restarts it.
        tick(3);
        step(1, TOP);
        tick(4);
        step(0, 0);
        chk("R9 second strobe", rev_stb_o, 1);
        chk("R9 new direction", rev_up_o, 0);
        tick(MINC - 1);
        chk("R9 window restarted", marker_o, 1);
        tick(1);
        chk("R9 clears after new window", marker_o, 0);

        tick(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * CLK_NS);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule